// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives the bit timing of a CAN controller from the system clock. A programmable prescaler divides the clock into time quanta. A segment counter then splits every bit into one synchronisation quantum, a first phase segment and a second phase segment. At the end of the first segment the block samples the receive line and emits a sample strobe with the sampled value. At the end of the second segment it emits a bit-start strobe, which the transmitter uses as its launch point.

The block resynchronises to recessive-to-dominant (falling) edges on the receive line. An edge that arrives late, inside the first segment, stretches that segment. An edge that arrives early, inside the second segment, cuts that segment short. The size of either correction is capped by the programmed jump width, and only one correction is made per bit. An optional voter can replace the single sample with a majority of three consecutive clock samples.

Two configuration words are written through a simple write port: the prescaler word and the timing word. Each field holds its value minus one. The words can only be loaded while the configuration-mode acknowledge input is high. While that input is high, the timing is also held at the start of a bit.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted and after it is released, `sample_stb` and `bit_start` are 0, `sample_bit` is 1, and every configuration field is 0.
- R2: The prescaler word (`wr_sel`=0) holds the quantum length minus one in bits [9:0]. For field values of 3 and above, one time quantum lasts field+1 clock cycles.
- R3: A prescaler field value of 0, 1 or 2 yields a quantum of 4 clock cycles.
- R4: The timing word (`wr_sel`=1) holds first-segment length minus one in bits [3:0] (1..16 quanta), second-segment length minus one in bits [6:4] (1..8), triple-sampling select in bit 7, and jump width minus one in bits [9:8] (1..4). Without resynchronisation a bit lasts 1+TS1+TS2 quanta.
- R5: `sample_stb` is a one-cycle pulse in the cycle after the clock edge that ends the first segment. `bit_start` is a one-cycle pulse in the cycle after the edge that ends the second segment. The two never coincide.
- R6: A falling edge seen while the counter is in quantum k (counted from 0) of the first segment lengthens that segment by min(k+1, jump width) quanta.
- R7: A falling edge seen in quantum k of the second segment shortens it by min(TS2−k, jump width) quanta. If that leaves no quanta after the current one, the bit ends at the end of the current quantum.
- R8: A falling edge seen in the synchronisation quantum causes no adjustment. At most one edge per bit is acted on, so later edges in the same bit are ignored.
- R9: With bit 7 clear, `sample_bit` is the receive level at the edge that ends the first segment. With bit 7 set, it is the majority of the levels at that edge and the two edges before it.
- R10: A write while `cfg_mode` is 0 changes no field, so the bit timing stays as it was.
- R11: While `cfg_mode` is 1, neither strobe fires and the counters stay at the start of a bit. After `cfg_mode` falls, the first `bit_start` appears (1+TS1+TS2)·quantum cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration-mode acknowledge; enables writes and holds the timing |
| wr_en | input | 1 | Write strobe for a configuration word |
| wr_sel | input | 1 | 0 selects the prescaler word, 1 selects the timing word |
| wr_data | input | 16 | Configuration word value |
| rx_in | input | 1 | Receive line, 1 is recessive |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_bit | output | 1 | Value sampled at the last sample point |
| bit_start | output | 1 | One-cycle pulse at the start of each bit (transmit point) |

## Verification
The bench builds the block with its default parameters: a 10-bit prescaler field with a floor of 4, and the three-sample voter present. These settings let it reach the clamp at small prescaler values and majority voting with glitchy input, as well as single sampling. It uses short segments (a 4-cycle quantum with a first segment of 8 and a second segment of 4) so that edges can be placed in chosen quanta, including the last ones of each segment where the jump-width cap binds. Pseudo-random receive toggling with jump widths of 2 and 4 drives many resynchronisations in both sampling modes.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   // field widths of the two configuration words
   localparam int BRP_W  = 10;
   localparam int TS1_W  = 4;
   localparam int TS2_W  = 3;
   localparam int SJW_W  = 2;
   // positions inside the timing word
   localparam int TS1_LSB    = 0;
   localparam int TS2_LSB    = 4;
   localparam int TRIPLE_BIT = 7;
   localparam int SJW_LSB    = 8;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_ONE  = 2'd1,
      SEG_TWO  = 2'd2
   } seg_e;

   typedef struct packed {
      logic [BRP_W-1:0] brp_m1;
      logic [TS1_W-1:0] ts1_m1;
      logic [TS2_W-1:0] ts2_m1;
      logic [SJW_W-1:0] sjw_m1;
      logic             triple;
   } timing_cfg_t;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
   import cbt_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output timing_cfg_t       cfg
);
   localparam int TIMING_TOP = SJW_LSB + SJW_W;

   if (WORD_W < TIMING_TOP || WORD_W < BRP_W) begin : g_bad_word
      $error("cbt_cfg_regs: WORD_W too narrow for the configuration fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en && cfg_mode) begin
         if (!wr_sel) begin
            cfg.brp_m1 <= wr_data[BRP_W-1:0];
         end else begin
            cfg.ts1_m1 <= wr_data[TS1_LSB +: TS1_W];
            cfg.ts2_m1 <= wr_data[TS2_LSB +: TS2_W];
            cfg.sjw_m1 <= wr_data[SJW_LSB +: SJW_W];
            cfg.triple <= wr_data[TRIPLE_BIT];
         end
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> $stable(cfg)); // R10
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
   import cbt_pkg::*;
#(
   parameter int BRP_MIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [BRP_W-1:0] brp_m1,
   output logic             tq_tick
);
   localparam logic [BRP_W-1:0] LIM_FLOOR = BRP_W'(BRP_MIN - 1);

   if (BRP_MIN < 2 || BRP_MIN > (1 << BRP_W)) begin : g_bad_min
      $error("cbt_prescaler: BRP_MIN out of range");
   end

   logic [BRP_W-1:0] lim;
   logic [BRP_W-1:0] pc;

   // small divisors are raised to the floor
   assign lim     = (brp_m1 < LIM_FLOOR) ? LIM_FLOOR : brp_m1;
   assign tq_tick = run && (pc == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (!run || pc == lim) begin
         pc <= '0;
      end else begin
         pc <= pc + BRP_W'(1);
      end
   end

   AST_PC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pc <= lim); // R3
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tq_tick |=> !tq_tick); // R2
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   input  logic triple_sel,
   input  logic take,
   output logic rx_prev,
   output logic sample_bit
);
   logic [1:0] hist;
   logic       vote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 2'b11;
      else        hist <= {hist[0], rx_in};
   end

   assign rx_prev = hist[0];

   if (TRIPLE_EN) begin : g_vote3
      logic maj;
      assign maj  = (rx_in & hist[0]) | (rx_in & hist[1]) | (hist[0] & hist[1]);
      assign vote = triple_sel ? maj : rx_in;

      AST_VOTE_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
         (take && triple_sel) |=> sample_bit ==
            (($past(rx_in) & $past(rx_in, 2)) | ($past(rx_in) & $past(rx_in, 3)) |
             ($past(rx_in, 2) & $past(rx_in, 3)))); // R9
   end else begin : g_vote1
      // mode bit has no effect when the voter is left out
      assign vote = rx_in | (triple_sel & 1'b0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sample_bit <= 1'b1;
      else if (take) sample_bit <= vote;
   end

   AST_VOTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !triple_sel) |=> sample_bit == $past(rx_in)); // R9
endmodule

// File: rtl/cbt_segment.sv
module cbt_segment
   import cbt_pkg::*;
#(
   parameter int QW = TS1_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tq_tick,
   input  logic             edge_fall,
   input  logic [TS1_W-1:0] ts1_m1,
   input  logic [TS2_W-1:0] ts2_m1,
   input  logic [SJW_W-1:0] sjw_m1,
   output logic             end_ts1,
   output logic             end_bit
);
   if ((1 << QW) <= (1 << TS1_W) + (1 << SJW_W) + 1) begin : g_bad_qw
      $error("cbt_segment: QW cannot hold a stretched first segment");
   end

   logic [QW-1:0] ts1_len, ts2_len, sjw_len;
   logic [QW-1:0] q, ext, cut;
   logic [QW-1:0] late_err, early_err;
   seg_e          seg;
   logic          taken;
   logic          resync;

   function automatic logic [QW-1:0] cap(input logic [QW-1:0] a, input logic [QW-1:0] b);
      return (a < b) ? a : b;
   endfunction

   assign ts1_len   = QW'(ts1_m1) + QW'(1);
   assign ts2_len   = QW'(ts2_m1) + QW'(1);
   assign sjw_len   = QW'(sjw_m1) + QW'(1);
   assign late_err  = q + QW'(1);
   assign early_err = ts2_len - q;
   assign resync    = run && edge_fall && !taken;

   assign end_ts1 = tq_tick && (seg == SEG_ONE) && ((q + QW'(1)) >= (ts1_len + ext));
   assign end_bit = tq_tick && (seg == SEG_TWO) && ((q + QW'(1) + cut) >= ts2_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg   <= SEG_SYNC;
         q     <= '0;
         ext   <= '0;
         cut   <= '0;
         taken <= 1'b0;
      end else if (!run) begin
         seg   <= SEG_SYNC;
         q     <= '0;
         ext   <= '0;
         cut   <= '0;
         taken <= 1'b0;
      end else begin
         if (resync) begin
            taken <= 1'b1;
            if (seg == SEG_ONE)      ext <= cap(late_err, sjw_len);
            else if (seg == SEG_TWO) cut <= cap(early_err, sjw_len);
         end
         if (tq_tick) begin
            unique case (seg)
               SEG_SYNC: begin
                  seg <= SEG_ONE;
                  q   <= '0;
               end
               SEG_ONE: begin
                  if (end_ts1) begin
                     seg <= SEG_TWO;
                     q   <= '0;
                  end else begin
                     q <= q + QW'(1);
                  end
               end
               SEG_TWO: begin
                  if (end_bit) begin
                     seg   <= SEG_SYNC;
                     q     <= '0;
                     ext   <= '0;
                     cut   <= '0;
                     taken <= 1'b0;
                  end else begin
                     q <= q + QW'(1);
                  end
               end
               default: begin
                  seg <= SEG_SYNC;
                  q   <= '0;
               end
            endcase
         end
      end
   end

   AST_EXT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ext <= sjw_len); // R6
   AST_CUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cut <= sjw_len); // R7
   AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && run && !end_bit) |=> taken); // R8
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
   import cbt_pkg::*;
#(
   parameter bit TRIPLE_EN = 1'b1,
   parameter int BRP_MIN   = 4,
   parameter int WORD_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mode,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rx_in,
   output logic              sample_stb,
   output logic              sample_bit,
   output logic              bit_start
);
   localparam int QW = TS1_W + 2;

   timing_cfg_t cfg;
   logic        run;
   logic        tq_tick;
   logic        rx_prev;
   logic        edge_fall;
   logic        end_ts1;
   logic        end_bit;

   assign run       = !cfg_mode;
   assign edge_fall = run && rx_prev && !rx_in;

   cbt_cfg_regs #(.WORD_W(WORD_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .cfg(cfg)
   );

   cbt_prescaler #(.BRP_MIN(BRP_MIN)) i_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .brp_m1(cfg.brp_m1), .tq_tick(tq_tick)
   );

   cbt_segment #(.QW(QW)) i_seg (
      .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick), .edge_fall(edge_fall),
      .ts1_m1(cfg.ts1_m1), .ts2_m1(cfg.ts2_m1), .sjw_m1(cfg.sjw_m1),
      .end_ts1(end_ts1), .end_bit(end_bit)
   );

   cbt_sampler #(.TRIPLE_EN(TRIPLE_EN)) i_samp (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .triple_sel(cfg.triple),
      .take(end_ts1), .rx_prev(rx_prev), .sample_bit(sample_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_stb <= 1'b0;
         bit_start  <= 1'b0;
      end else begin
         sample_stb <= end_ts1;
         bit_start  <= end_bit;
      end
   end

   AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |=> (!sample_stb && !bit_start)); // R11
   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_start)); // R5
   AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb); // R5
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rx_in = 1'b1;
   logic        sample_stb, sample_bit, bit_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   can_bit_timer i_can_bit_timer (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rx_in(rx_in), .sample_stb(sample_stb),
      .sample_bit(sample_bit), .bit_start(bit_start)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference, advanced once per rising edge
   int m_brp, m_ts1, m_ts2, m_sjw, m_pc, m_seg, m_q, m_ext, m_cut;
   bit m_tri, m_taken, m_h0, m_h1;
   bit exp_stb, exp_bs, exp_bit;

   always @(posedge clk) begin
      int quantum, l1, l2, sj, oq, os;
      bit tick, e1, eb, vote, fall, run;
      if (!rst_n) begin
         m_brp = 0; m_ts1 = 0; m_ts2 = 0; m_sjw = 0; m_tri = 0;
         m_pc = 0; m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_taken = 0;
         m_h0 = 1; m_h1 = 1;
         exp_stb = 0; exp_bs = 0; exp_bit = 1;
      end else begin
         quantum = (m_brp + 1 < 4) ? 4 : m_brp + 1;
         l1 = m_ts1 + 1; l2 = m_ts2 + 1; sj = m_sjw + 1;
         oq = m_q; os = m_seg;
         run  = !cfg_mode;
         tick = run && (m_pc == quantum - 1);
         e1 = tick && os == 1 && (oq + 1 >= l1 + m_ext);
         eb = tick && os == 2 && (oq + 1 + m_cut >= l2);
         vote = m_tri ? ((int'(rx_in) + int'(m_h0) + int'(m_h1)) >= 2) : rx_in;
         fall = run && m_h0 && !rx_in;
         exp_stb = e1;
         exp_bs  = eb;
         if (e1) exp_bit = vote;
         if (!run) begin
            m_pc = 0; m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_taken = 0;
         end else begin
            if (fall && !m_taken) begin
               m_taken = 1;
               if (os == 1) m_ext = (oq + 1 < sj) ? oq + 1 : sj;
               else if (os == 2) m_cut = (l2 - oq < sj) ? l2 - oq : sj;
            end
            if (tick) begin
               if (os == 0) begin m_seg = 1; m_q = 0; end
               else if (os == 1) begin
                  if (e1) begin m_seg = 2; m_q = 0; end else m_q = oq + 1;
               end else begin
                  if (eb) begin
                     m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_taken = 0;
                  end else m_q = oq + 1;
               end
            end
            m_pc = (m_pc == quantum - 1) ? 0 : m_pc + 1;
         end
         if (wr_en && cfg_mode) begin
            if (!wr_sel) m_brp = int'(wr_data[9:0]);
            else begin
               m_ts1 = int'(wr_data[3:0]);
               m_ts2 = int'(wr_data[6:4]);
               m_tri = wr_data[7];
               m_sjw = int'(wr_data[9:8]);
            end
         end
         m_h1 = m_h0;
         m_h0 = rx_in;
      end
   end

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sample_stb == exp_stb, "R5 sample_stb", int'(sample_stb), int'(exp_stb));
         chk(bit_start == exp_bs, "R5 bit_start", int'(bit_start), int'(exp_bs));
         chk(sample_bit == exp_bit, "R9 sample_bit", int'(sample_bit), int'(exp_bit));
      end
   end

   task automatic write_word(input bit sel, input logic [15:0] val);
      @(negedge clk);
      cfg_mode = 1'b1; wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_bs(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_start);
   endtask

   task automatic wait_ss(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_stb);
   endtask

   // falling edge w cycles after a bit start; returns bit length
   task automatic edge_bit(input int w, output int n);
      int d;
      wait_bs(d);
      repeat (w) @(negedge clk);
      rx_in = 1'b0;
      n = w;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_start);
      rx_in = 1'b1;
      wait_bs(d);
   endtask

   initial begin
      int n, d, quiet;
      logic [15:0] lfsr;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(sample_stb == 1'b0 && bit_start == 1'b0, "R1 strobes in reset", int'(sample_stb | bit_start), 0);
      chk(sample_bit == 1'b1, "R1 sample_bit in reset", int'(sample_bit), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sample_bit == 1'b1 && !bit_start, "R1 after reset", int'(sample_bit), 1);

      // R3, R11: default fields give 4-cycle quanta and a 3-quantum bit
      cfg_mode = 1'b0;
      wait_bs(n);
      chk(n == 12, "R11 first bit after release", n, 12);
      wait_bs(n);
      chk(n == 12, "R3 default bit length", n, 12);

      // R11: held while in configuration mode
      @(negedge clk);
      cfg_mode = 1'b1;
      quiet = 0;
      repeat (40) begin
         @(negedge clk);
         if (sample_stb || bit_start) quiet++;
      end
      chk(quiet == 0, "R11 no strobes in config mode", quiet, 0);

      // R2, R4, R5: prescaler 10, TS1 5, TS2 3
      write_word(1'b0, 16'd9);
      write_word(1'b1, 16'h0024);
      cfg_mode = 1'b0;
      wait_bs(n);
      chk(n == 90, "R11 restart after config", n, 90);
      wait_ss(n);
      chk(n == 60, "R5 sample point offset", n, 60);
      wait_bs(n);
      chk(n == 30, "R4 second segment length", n, 30);

      // R3: field 2 clamps to 4; R2: field 4 gives 5
      write_word(1'b1, 16'h0000);
      write_word(1'b0, 16'd2);
      cfg_mode = 1'b0;
      wait_bs(d);
      wait_bs(n);
      chk(n == 12, "R3 clamp of small prescaler", n, 12);
      write_word(1'b0, 16'd4);
      cfg_mode = 1'b0;
      wait_bs(d);
      wait_bs(n);
      chk(n == 15, "R2 prescaler field 4", n, 15);

      // R10: writes outside configuration mode are ignored
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd50;
      @(negedge clk);
      wr_sel = 1'b1; wr_data = 16'h03FF;
      @(negedge clk);
      wr_en = 1'b0;
      wait_bs(d);
      wait_bs(n);
      chk(n == 15, "R10 ignored writes", n, 15);

      // resynchronisation: quantum 4, TS1 8, TS2 4, jump width 2
      write_word(1'b0, 16'd3);
      write_word(1'b1, 16'h0137);
      cfg_mode = 1'b0;
      wait_bs(d);
      wait_bs(n);
      chk(n == 52, "R4 nominal bit length", n, 52);
      edge_bit(4, n);
      chk(n == 56, "R6 late edge in first quantum", n, 56);
      edge_bit(12, n);
      chk(n == 60, "R6 late edge capped", n, 60);
      edge_bit(40, n);
      chk(n == 44, "R7 early edge capped", n, 44);
      edge_bit(44, n);
      chk(n == 48, "R7 early edge ends current quantum", n, 48);
      edge_bit(0, n);
      chk(n == 52, "R8 edge in sync quantum", n, 52);
      // R8: second edge in the same bit is ignored
      wait_bs(d);
      rx_in = 1'b0;
      repeat (2) @(negedge clk);
      rx_in = 1'b1;
      repeat (18) @(negedge clk);
      rx_in = 1'b0;
      n = 20;
      do begin
         @(negedge clk);
         n++;
      end while (!bit_start);
      rx_in = 1'b1;
      chk(n == 52, "R8 one resync per bit", n, 52);

      // R9: noisy line, triple then single sampling, jump widths 2 and 4
      lfsr = 16'hACE1;
      write_word(1'b1, 16'h01B7);
      cfg_mode = 1'b0;
      repeat (1500) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[2:0] == 3'd0) rx_in = ~rx_in;
      end
      write_word(1'b1, 16'h0337);
      cfg_mode = 1'b0;
      repeat (1500) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[1:0] == 2'd0) rx_in = ~rx_in;
      end
      write_word(1'b1, 16'h03B2);
      cfg_mode = 1'b0;
      repeat (1500) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[1:0] == 2'd0) rx_in = ~rx_in;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule